// File: doc/BRIEF.md
# Debug Breakpoint and Execution Controller

This block sits next to a CPU core and watches every memory access the core makes. The host programs a small set of breakpoint comparators. Each comparator is qualified by memory space, by access direction and, if wanted, by a masked data pattern. When an access hits, the controller lets the current instruction finish. It then holds the CPU at the next instruction boundary and records which comparator fired.

The host drives execution through a four-code command port. Halt stops the core at the next boundary. Run releases it. Step releases it for exactly one boundary. Skip asks the core to jump over the pending instruction without executing it. Configuration is written through a simple indexed register port.

When no comparator is enabled and the core runs freely, the comparator inputs are forced to zero so that the match logic does not toggle.

Top module: `dbg_exec_ctrl`

## Requirements
- R1: After reset, cpu_hold, halted, skip_req and hit_valid are low, hit_idx is 0, and every comparator is disabled with all configuration cleared.
- R2: A comparator hits only when all of the following are true: its enable bit is set, bus_space equals its space field (0 program, 1 internal data, 2 external data, 3 special registers), bus_addr equals its address, and either (bus_rd with read-enable set) or (bus_wr with write-enable set).
- R3: With data-compare enabled, a hit also needs bus_data to equal the stored value on every bit where the mask holds 1. With data-compare disabled, bus_data is ignored.
- R4: A hit seen while running sends the unit to the halted state at the first cycle where instr_bnd is high, counting the hit cycle itself. cpu_hold and halted then read 1 from the next cycle. hit_valid reads 1, and hit_idx gives the comparator.
- R5: When several comparators hit together, the lowest index is recorded. Once a hit is pending or recorded, later hits before the halt do not change hit_idx.
- R6: Command code 0 (halt) given while running halts at the next instruction boundary, with hit_valid low. cpu_hold only falls in the cycle after a command.
- R7: Command code 1 (run) in any non-running state returns to running. It clears cpu_hold, halted and hit_valid from the next cycle, and a pending halt is cancelled.
- R8: After a run or step command, matches are ignored until a cycle in which both bus_rd and bus_wr are low. A strobe still held from the access that caused the halt therefore cannot re-trigger.
- R9: Command code 2 (step) while halted drops cpu_hold for one instruction and halts again at the next instr_bnd. While not halted it has no effect.
- R10: Command code 3 (skip) while halted raises skip_req for exactly the next cycle, and the unit stays halted. Outside the halted state it has no effect.
- R11: A configuration write selects comparator cfg_idx and field cfg_field. Field 0 is control: bit0 enable, bits2:1 space, bit3 read-enable, bit4 write-enable, bit5 data-compare. Field 1 is the address. Field 2 carries the data value in bits 7:0 and the mask in bits 15:8. Field 3 changes nothing.
- R12: With no comparator enabled, no access ever causes a halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Comparator selected for the write |
| cfg_field | input | 2 | Field code within the comparator |
| cfg_wdata | input | 16 | Configuration write value |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code: 0 halt, 1 run, 2 step, 3 skip |
| bus_addr | input | 16 | Access address from the CPU |
| bus_data | input | 8 | Access data from the CPU |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_space | input | 2 | Memory space of the access |
| instr_bnd | input | 1 | Instruction boundary strobe |
| cpu_hold | output | 1 | Holds the CPU at the boundary |
| skip_req | output | 1 | One-cycle request to skip the pending instruction |
| halted | output | 1 | Halted status |
| hit_valid | output | 1 | The last halt came from a breakpoint |
| hit_idx | output | 2 | Index of the comparator that fired |

## Verification
The properties assume that the CPU raises instr_bnd only while it is running, so the boundary strobe is the only way into the halted state. They also assume that a command is a single-cycle strobe and that configuration is not rewritten in the same cycle as an access it should match. The stimulus follows these rules. It drives accesses and boundaries only between commands, and after every run command it inserts a cycle with both strobes low before the next intended hit. The only exception is the deliberate strobe-held sequence that tests re-trigger masking.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    typedef enum logic [1:0] {
        CMD_HALT = 2'd0,
        CMD_RUN  = 2'd1,
        CMD_STEP = 2'd2,
        CMD_SKIP = 2'd3
    } dbg_cmd_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PEND = 2'd1,
        ST_HALT = 2'd2,
        ST_STEP = 2'd3
    } dbg_state_e;

    localparam logic [1:0] FLD_CTRL = 2'd0;
    localparam logic [1:0] FLD_ADDR = 2'd1;
    localparam logic [1:0] FLD_DATA = 2'd2;

    localparam int CB_EN    = 0;
    localparam int CB_SPACE = 1;
    localparam int CB_RD    = 3;
    localparam int CB_WR    = 4;
    localparam int CB_DCMP  = 5;
endpackage

// File: rtl/dbg_bp_cmp.sv
module dbg_bp_cmp
    import dbg_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int CW  = 16,
    parameter int IW  = 2,
    parameter int IDX = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [1:0]    cfg_field,
    input  logic [CW-1:0] cfg_wdata,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          rd,
    input  logic          wr,
    input  logic [1:0]    space,
    output logic          armed,
    output logic          match
);
    typedef struct packed {
        logic          en;
        logic [1:0]    space;
        logic          rd_en;
        logic          wr_en;
        logic          dcmp;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [DW-1:0] mask;
    } bp_cfg_t;

    bp_cfg_t cfg_d, cfg_q;
    logic    sel;

    assign sel = cfg_we && (cfg_idx == IW'(IDX));

    always_comb begin
        cfg_d = cfg_q;
        if (sel) begin
            case (cfg_field)
                FLD_CTRL: begin
                    cfg_d.en    = cfg_wdata[CB_EN];
                    cfg_d.space = cfg_wdata[CB_SPACE +: 2];
                    cfg_d.rd_en = cfg_wdata[CB_RD];
                    cfg_d.wr_en = cfg_wdata[CB_WR];
                    cfg_d.dcmp  = cfg_wdata[CB_DCMP];
                end
                FLD_ADDR: cfg_d.addr = cfg_wdata[AW-1:0];
                FLD_DATA: begin
                    cfg_d.data = cfg_wdata[DW-1:0];
                    cfg_d.mask = cfg_wdata[2*DW-1:DW];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    logic kind_ok, addr_ok, data_ok;

    always_comb begin
        kind_ok = (cfg_q.rd_en && rd) || (cfg_q.wr_en && wr);
        addr_ok = (addr == cfg_q.addr) && (space == cfg_q.space);
        data_ok = !cfg_q.dcmp || (((data ^ cfg_q.data) & cfg_q.mask) == '0);
        match   = cfg_q.en && kind_ok && addr_ok && data_ok;
    end

    assign armed = cfg_q.en;
endmodule

// File: rtl/dbg_hit_pick.sv
module dbg_hit_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  match,
    output logic          any,
    output logic [IW-1:0] id
);
    always_comb begin
        any = |match;
        id  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) id = IW'(i);
        end
    end
endmodule

// File: rtl/dbg_exec_fsm.sv
module dbg_exec_fsm
    import dbg_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic          instr_bnd,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic          hit_any,
    input  logic [IW-1:0] hit_id,
    output logic          cpu_hold,
    output logic          halted,
    output logic          skip_req,
    output logic          hit_valid,
    output logic [IW-1:0] hit_idx,
    output logic          running
);
    typedef struct packed {
        dbg_state_e    st;
        logic          hv;
        logic [IW-1:0] idx;
        logic          skip;
        logic          mask;
    } fsm_t;

    fsm_t q, d;
    logic c_halt, c_run, c_step, c_skip, hit_ok;

    always_comb begin
        c_halt = cmd_valid && (cmd_op == CMD_HALT);
        c_run  = cmd_valid && (cmd_op == CMD_RUN);
        c_step = cmd_valid && (cmd_op == CMD_STEP);
        c_skip = cmd_valid && (cmd_op == CMD_SKIP);
        hit_ok = hit_any && !q.mask && ((q.st == ST_RUN) || (q.st == ST_STEP));

        d      = q;
        d.skip = 1'b0;
        if (q.mask && !bus_rd && !bus_wr) d.mask = 1'b0;

        if (c_run && (q.st != ST_RUN)) begin
            d.st   = ST_RUN;
            d.hv   = 1'b0;
            d.mask = 1'b1;
        end else begin
            case (q.st)
                ST_RUN: begin
                    if (c_halt || hit_ok) begin
                        d.st = instr_bnd ? ST_HALT : ST_PEND;
                        if (hit_ok) begin
                            d.hv  = 1'b1;
                            d.idx = hit_id;
                        end
                    end
                end
                ST_PEND: begin
                    if (instr_bnd) d.st = ST_HALT;
                end
                ST_HALT: begin
                    if (c_step) begin
                        d.st   = ST_STEP;
                        d.hv   = 1'b0;
                        d.mask = 1'b1;
                    end else if (c_skip) begin
                        d.skip = 1'b1;
                    end
                end
                ST_STEP: begin
                    if (hit_ok && !q.hv) begin
                        d.hv  = 1'b1;
                        d.idx = hit_id;
                    end
                    if (instr_bnd)   d.st = ST_HALT;
                    else if (c_halt) d.st = ST_PEND;
                end
                default: d.st = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{st: ST_RUN, hv: 1'b0, idx: '0, skip: 1'b0, mask: 1'b0};
        else     q <= d;
    end

    assign cpu_hold  = (q.st == ST_HALT);
    assign halted    = (q.st == ST_HALT);
    assign skip_req  = q.skip;
    assign hit_valid = q.hv;
    assign hit_idx   = q.idx;
    assign running   = (q.st == ST_RUN);
endmodule

// File: rtl/dbg_exec_ctrl.sv
module dbg_exec_ctrl
    import dbg_pkg::*;
#(
    parameter int  NUM_BP = 4,
    parameter int  ADDR_W = 16,
    parameter int  DATA_W = 8,
    localparam int IW     = (NUM_BP > 1) ? $clog2(NUM_BP) : 1,
    localparam int CW     = (ADDR_W > 2 * DATA_W) ? ADDR_W : 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IW-1:0]     cfg_idx,
    input  logic [1:0]        cfg_field,
    input  logic [CW-1:0]     cfg_wdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_space,
    input  logic              instr_bnd,
    output logic              cpu_hold,
    output logic              skip_req,
    output logic              halted,
    output logic              hit_valid,
    output logic [IW-1:0]     hit_idx
);
    logic [NUM_BP-1:0] armed_v, match_v;
    logic              any_en, active, running, hit_any;
    logic [IW-1:0]     hit_id;

    logic [ADDR_W-1:0] g_addr;
    logic [DATA_W-1:0] g_data;
    logic              g_rd, g_wr;
    logic [1:0]        g_space;

    assign any_en  = |armed_v;
    assign active  = any_en || !running;
    assign g_addr  = bus_addr & {ADDR_W{active}};
    assign g_data  = bus_data & {DATA_W{active}};
    assign g_rd    = bus_rd & active;
    assign g_wr    = bus_wr & active;
    assign g_space = bus_space & {2{active}};

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        dbg_bp_cmp #(
            .AW(ADDR_W), .DW(DATA_W), .CW(CW), .IW(IW), .IDX(i)
        ) u_cmp (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (cfg_we),
            .cfg_idx   (cfg_idx),
            .cfg_field (cfg_field),
            .cfg_wdata (cfg_wdata),
            .addr      (g_addr),
            .data      (g_data),
            .rd        (g_rd),
            .wr        (g_wr),
            .space     (g_space),
            .armed     (armed_v[i]),
            .match     (match_v[i])
        );
    end

    dbg_hit_pick #(.N(NUM_BP), .IW(IW)) u_pick (
        .match (match_v),
        .any   (hit_any),
        .id    (hit_id)
    );

    dbg_exec_fsm #(.IW(IW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .instr_bnd (instr_bnd),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .hit_any   (hit_any),
        .hit_id    (hit_id),
        .cpu_hold  (cpu_hold),
        .halted    (halted),
        .skip_req  (skip_req),
        .hit_valid (hit_valid),
        .hit_idx   (hit_idx),
        .running   (running)
    );
endmodule

// File: rtl/dbg_exec_ctrl_chk.sv
module dbg_exec_ctrl_chk
    import dbg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       instr_bnd,
    input logic       cpu_hold,
    input logic       skip_req,
    input logic       any_en,
    input logic       hit_any
);
    // R4
    hold_rise_bnd_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_hold) |-> $past(instr_bnd));

    // R6
    hold_fall_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_hold) |-> $past(cmd_valid));

    // R7
    run_release_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_hold && cmd_valid && cmd_op == CMD_RUN) |=> !cpu_hold);

    // R9
    step_release_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_hold && cmd_valid && cmd_op == CMD_STEP) |=> !cpu_hold);

    // R10
    skip_halted_chk: assert property (@(posedge clk) disable iff (rst)
        skip_req |-> (cpu_hold && $past(cmd_valid && cmd_op == CMD_SKIP)));

    // R12
    idle_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        !any_en |-> !hit_any);
endmodule

bind dbg_exec_ctrl dbg_exec_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .instr_bnd (instr_bnd),
    .cpu_hold  (cpu_hold),
    .skip_req  (skip_req),
    .any_en    (any_en),
    .hit_any   (hit_any)
);

// File: tb/tb_dbg_exec_ctrl.sv
module tb_dbg_exec_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [1:0]  cfg_field = '0;
    logic [15:0] cfg_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_space = '0;
    logic        instr_bnd = 1'b0;
    logic        cpu_hold, skip_req, halted, hit_valid;
    logic [1:0]  hit_idx;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dbg_exec_ctrl dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_space(bus_space),
        .instr_bnd(instr_bnd), .cpu_hold(cpu_hold), .skip_req(skip_req),
        .halted(halted), .hit_valid(hit_valid), .hit_idx(hit_idx)
    );

    // behavioural reference: mode 0 free, 1 waiting boundary, 2 stopped, 3 single step
    int m_mode = 0;
    int m_idx = 0;
    bit m_hv = 0, m_skip = 0, m_mask = 0;
    bit c_en[4], c_rd[4], c_wr[4], c_dc[4];
    int c_sp[4], c_ad[4], c_da[4], c_mk[4];

    function automatic int first_hit();
        for (int i = 0; i < 4; i++) begin
            if (c_en[i] && c_sp[i] == int'(bus_space) && c_ad[i] == int'(bus_addr)
                && ((c_rd[i] && bus_rd) || (c_wr[i] && bus_wr))
                && (!c_dc[i] || ((int'(bus_data) ^ c_da[i]) & c_mk[i]) == 0))
                return i;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        int h, nm, ni;
        bit nh, nk, nmask;
        if (rst) begin
            m_mode <= 0; m_idx <= 0; m_hv <= 0; m_skip <= 0; m_mask <= 0;
            for (int i = 0; i < 4; i++) begin
                c_en[i] <= 0; c_rd[i] <= 0; c_wr[i] <= 0; c_dc[i] <= 0;
                c_sp[i] <= 0; c_ad[i] <= 0; c_da[i] <= 0; c_mk[i] <= 0;
            end
        end else begin
            h = first_hit();
            if (!((m_mode == 0 || m_mode == 3) && !m_mask)) h = -1;
            nm = m_mode; ni = m_idx; nh = m_hv; nk = 0; nmask = m_mask;
            if (m_mask && !bus_rd && !bus_wr) nmask = 0;
            if (cmd_valid && cmd_op == 1 && m_mode != 0) begin
                nm = 0; nh = 0; nmask = 1;
            end else if (m_mode == 0) begin
                if ((cmd_valid && cmd_op == 0) || h >= 0) begin
                    nm = instr_bnd ? 2 : 1;
                    if (h >= 0) begin nh = 1; ni = h; end
                end
            end else if (m_mode == 1) begin
                if (instr_bnd) nm = 2;
            end else if (m_mode == 2) begin
                if (cmd_valid && cmd_op == 2) begin nm = 3; nh = 0; nmask = 1; end
                else if (cmd_valid && cmd_op == 3) nk = 1;
            end else begin
                if (h >= 0 && !m_hv) begin nh = 1; ni = h; end
                if (instr_bnd) nm = 2;
                else if (cmd_valid && cmd_op == 0) nm = 1;
            end
            m_mode <= nm; m_idx <= ni; m_hv <= nh; m_skip <= nk; m_mask <= nmask;
            if (cfg_we && cfg_field == 0) begin
                c_en[cfg_idx] <= cfg_wdata[0]; c_sp[cfg_idx] <= int'(cfg_wdata[2:1]);
                c_rd[cfg_idx] <= cfg_wdata[3]; c_wr[cfg_idx] <= cfg_wdata[4];
                c_dc[cfg_idx] <= cfg_wdata[5];
            end else if (cfg_we && cfg_field == 1) begin
                c_ad[cfg_idx] <= int'(cfg_wdata);
            end else if (cfg_we && cfg_field == 2) begin
                c_da[cfg_idx] <= int'(cfg_wdata[7:0]); c_mk[cfg_idx] <= int'(cfg_wdata[15:8]);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            chk("R4 cpu_hold vs model", int'(cpu_hold), int'(m_mode == 2));
            chk("R6 halted vs model", int'(halted), int'(m_mode == 2));
            chk("R10 skip_req vs model", int'(skip_req), int'(m_skip));
            chk("R5 hit_valid vs model", int'(hit_valid), int'(m_hv));
            chk("R5 hit_idx vs model", int'(hit_idx), m_idx);
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_w(int idx, int fld, int val);
        cfg_we = 1; cfg_idx = 2'(idx); cfg_field = 2'(fld); cfg_wdata = 16'(val);
        tick();
        cfg_we = 0;
    endtask

    task automatic cmd(int op);
        cmd_valid = 1; cmd_op = 2'(op);
        tick();
        cmd_valid = 0;
    endtask

    task automatic acc(int sp, int ad, int da, bit rd, bit wr, bit bnd);
        bus_space = 2'(sp); bus_addr = 16'(ad); bus_data = 8'(da);
        bus_rd = rd; bus_wr = wr; instr_bnd = bnd;
        tick();
        bus_rd = 0; bus_wr = 0; instr_bnd = 0;
    endtask

    task automatic bnd_only();
        acc(0, 0, 0, 0, 0, 1);
    endtask

    task automatic status(string tag, bit hold, bit hv, int idx);
        chk(tag, int'(cpu_hold), int'(hold));
        chk(tag, int'(hit_valid), int'(hv));
        if (hv) chk(tag, int'(hit_idx), idx);
    endtask

    task automatic resume();
        cmd(1);
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 hold", int'(cpu_hold), 0);
        chk("R1 halted", int'(halted), 0);
        chk("R1 skip", int'(skip_req), 0);
        chk("R1 hit_valid", int'(hit_valid), 0);
        chk("R1 hit_idx", int'(hit_idx), 0);

        // R12 nothing enabled: no halt even on a programmed address
        cfg_w(0, 1, 16'h1234);
        acc(0, 16'h1234, 0, 1, 0, 1);
        tick();
        status("R12 idle no halt", 0, 0, 0);

        // R2 qualification by direction, space, address
        cfg_w(0, 0, 16'h0009);
        acc(0, 16'h1234, 0, 0, 1, 1);
        tick();
        status("R2 write ignored by read-only bp", 0, 0, 0);
        acc(1, 16'h1234, 0, 1, 0, 1);
        tick();
        status("R2 wrong space", 0, 0, 0);
        acc(0, 16'h1235, 0, 1, 0, 1);
        tick();
        status("R2 wrong address", 0, 0, 0);

        // R4 hit waits for the boundary
        acc(0, 16'h1234, 8'hAB, 1, 0, 0);
        status("R4 pending before boundary", 0, 1, 0);
        tick();
        chk("R4 still running", int'(cpu_hold), 0);
        bnd_only();
        status("R4 halted at boundary", 1, 1, 0);
        chk("R4 halted flag", int'(halted), 1);

        // R10 skip pulse while halted
        cmd(3);
        chk("R10 skip pulse", int'(skip_req), 1);
        chk("R10 still halted", int'(cpu_hold), 1);
        tick();
        chk("R10 skip one cycle", int'(skip_req), 0);

        // R8 strobe held across run: no re-trigger
        bus_space = 0; bus_addr = 16'h1234; bus_rd = 1;
        cmd_valid = 1; cmd_op = 1;
        tick();
        cmd_valid = 0;
        status("R7 run clears hold and hit", 0, 0, 0);
        tick();
        instr_bnd = 1;
        tick();
        instr_bnd = 0; bus_rd = 0;
        tick();
        status("R8 held strobe masked", 0, 0, 0);
        acc(0, 16'h1234, 0, 1, 0, 1);
        status("R4 hit with same-cycle boundary", 1, 1, 0);

        // R9 step
        cmd(2);
        status("R9 step releases", 0, 0, 0);
        tick();
        bnd_only();
        status("R9 step halts after one boundary", 1, 0, 0);
        cmd(2);
        tick();
        acc(0, 16'h1234, 0, 1, 0, 0);
        chk("R9 hit during step still running", int'(cpu_hold), 0);
        bnd_only();
        status("R9 step hit recorded", 1, 1, 0);

        resume();
        // R3 masked data compare on a special-register write
        cfg_w(2, 1, 16'h00F0);
        cfg_w(2, 2, 16'h0F05);
        cfg_w(2, 0, 16'h0037);
        acc(3, 16'h00F0, 8'h36, 0, 1, 1);
        tick();
        status("R3 data mismatch", 0, 0, 0);
        acc(3, 16'h00F0, 8'h35, 0, 1, 1);
        status("R3 masked data match", 1, 1, 2);
        resume();

        // R5 priority between simultaneous hits
        cfg_w(1, 1, 16'h4000); cfg_w(1, 0, 16'h000D);
        cfg_w(3, 1, 16'h4000); cfg_w(3, 0, 16'h000D);
        acc(2, 16'h4000, 8'hAB, 1, 0, 1);
        status("R5 lowest index wins", 1, 1, 1);
        resume();
        acc(0, 16'h1234, 8'hFF, 1, 0, 0);
        acc(2, 16'h4000, 0, 1, 0, 1);
        status("R5 first hit kept", 1, 1, 0);
        resume();

        // R6 host halt
        cmd(0);
        chk("R6 halt waits for boundary", int'(cpu_hold), 0);
        tick();
        bnd_only();
        status("R6 halted by command", 1, 0, 0);
        resume();
        cmd(0);
        cmd(1);
        bnd_only();
        tick();
        chk("R7 run cancels pending halt", int'(cpu_hold), 0);

        // R10, R9 commands ignored while running
        cmd(3);
        chk("R10 skip ignored when running", int'(skip_req), 0);
        cmd(2);
        bnd_only();
        tick();
        chk("R9 step ignored when running", int'(cpu_hold), 0);

        // R11 address rewrite and reserved field
        cfg_w(0, 1, 16'h2222);
        cfg_w(0, 3, 16'hFFFF);
        acc(0, 16'h1234, 0, 1, 0, 1);
        tick();
        status("R11 old address no longer hits", 0, 0, 0);
        acc(0, 16'h2222, 0, 1, 0, 1);
        status("R11 new address hits", 1, 1, 0);
        resume();
        cfg_w(0, 0, 16'h0008);
        acc(0, 16'h2222, 0, 1, 0, 1);
        tick();
        status("R11 disable bit clears bp", 0, 0, 0);

        repeat (3) tick();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule